// File: doc/BRIEF.md
# Serial ADC Conversion Master

This block is the host side of a serial link to a 12-bit, eight-input converter that runs its own internal conversion clock. A conversion request enters on a valid/ready port and carries the input number (0 to 7) and two analogue setup flags: span and polarity. The master then does four things in turn:

- It pulls chip select low.
- It shifts an 8-bit command out, most significant bit first. SCLK runs at a rate set from a configuration input.
- It parks SCLK low while the converter holds its busy strobe low.
- It collects the 12-bit result and returns it with the input number on a second valid/ready port.

The command and the readout are not one fixed-length transfer. The clock stops between them for as long as the converter needs, and a programmable timeout guards that wait. If the strobe does not complete in time, the master releases chip select and returns an error response instead of data. The request side sees back-pressure: `req_ready` is high only when the master is idle and no result is waiting. A result stays on `res_*`, unchanged, until the consumer raises `res_ready` in a cycle where `res_valid` is high. No new request is taken until that result has been consumed and chip select has stayed high for at least one full SCLK period.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 0, `res_valid` is 0 and `req_ready` is 1.
- R2: The command byte goes out MSB first as bit7 = 1, bits6..4 = input number, bit3 = span flag, bit2 = polarity flag, bits1..0 = 00. `adc_din` changes only while SCLK is low, so it is stable at every SCLK rising edge.
- R3: Each SCLK high phase lasts exactly H system clocks, and each low phase lasts at least H. H = `cfg_half`, except that values below 2 are used as 2.
- R4: From the eighth command falling edge until the strobe is seen high again, SCLK stays low. It never rises while chip select is low and the strobe is low.
- R5: The master takes D11 once the strobe is seen high. It takes D10 to D0 on the next eleven SCLK rising edges that each follow a falling edge. `res_data` is the 12 bits, MSB first.
- R6: `res_chan` equals the input number of the request that produced the response.
- R7: If the strobe has not gone low and then high within `cfg_timeout` system clocks of the last command bit, the master raises chip select and returns `res_error` = 1 with `res_data` = 0. Only 8 SCLK rising edges have then been issued.
- R8: Chip select is high whenever `res_valid` is 1. Between two transfers it stays high for at least 2·H system clocks.
- R9: `req_ready` is 1 only when the master is idle and no result is pending. `res_valid`, `res_data`, `res_chan` and `res_error` hold steady until `res_ready` is sampled high.
- R10: A transfer that completes issues exactly 20 SCLK rising edges: 8 for the command and 12 for the readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half | input | 8 | SCLK half period in system clocks (minimum 2 applied) |
| cfg_timeout | input | 16 | Strobe wait limit in system clocks |
| req_valid | input | 1 | Conversion request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_chan | input | 3 | Input number to convert |
| req_span | input | 1 | Span flag placed in the command byte |
| req_bipolar | input | 1 | Polarity flag placed in the command byte |
| res_valid | output | 1 | Response available |
| res_ready | input | 1 | Consumer takes the response |
| res_data | output | 12 | Conversion result (0 on error) |
| res_chan | output | 3 | Input number of this response |
| res_error | output | 1 | Strobe timeout occurred |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles low |
| adc_din | output | 1 | Command data to the converter |
| adc_dout | input | 1 | Result data from the converter |
| adc_sstrb | input | 1 | Converter busy strobe, low during conversion |

## Verification
Transfers are run with several mixes of input number, span and polarity. Result words are all-zeros, all-ones, single MSB, single LSB and alternating patterns. These patterns show up a bit-order reversal, a lost first or last bit, and an off-by-one in the readout count. The half-period setting is varied across 1 (clamped), 2, 3 and 5, and the conversion time is varied too. This separates SCLK timing errors from errors in the strobe wait. A converter that never finishes exercises the timeout path. Back-to-back requests and a stalled consumer show whether the release gap and the response hold are kept.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int CMD_BITS = 8;
  localparam int RES_BITS = 12;
  localparam int CHAN_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_READ,
    ST_GAP
  } host_st_e;

  // start bit, input number, span, polarity, two zero bits for internal-clock mode
  function automatic logic [CMD_BITS-1:0] make_cmd(
    input logic [CHAN_W-1:0] chan,
    input logic              span,
    input logic              bipolar
  );
    return {1'b1, chan, span, bipolar, 2'b00};
  endfunction
endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
  parameter int    STAGES  = 2,
  parameter logic  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (half < MIN_HALF) ? MIN_HALF : half;
  assign tick = en && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/adc_busy_timer.sv
module adc_busy_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] cnt;

  assign expired = en && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!en)      cnt <= '0;
    else if (!expired) cnt <= cnt + TO_W'(1);
  end
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    cfg_half,
  input  logic [TO_W-1:0]     cfg_timeout,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CHAN_W-1:0]   req_chan,
  input  logic                req_span,
  input  logic                req_bipolar,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [RES_BITS-1:0] res_data,
  output logic [CHAN_W-1:0]   res_chan,
  output logic                res_error,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                adc_din,
  input  logic                adc_dout,
  input  logic                adc_sstrb
);
  localparam int CNT_W = $clog2(RES_BITS);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_RES = CNT_W'(RES_BITS - 1);

  host_st_e              state;
  logic [CMD_BITS-1:0]   cmd_sh;
  logic [RES_BITS-1:0]   res_sh;
  logic [CHAN_W-1:0]     chan_q;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  gap_half;
  logic                  sstrb_s;
  logic                  tick;
  logic                  div_en;
  logic                  wait_en;
  logic                  expired;
  logic                  accept;

  adc_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (adc_sstrb),
    .q     (sstrb_s)
  );

  assign div_en = (state == ST_CMD) || (state == ST_READ) || (state == ST_GAP);

  adc_sclk_div #(.DIV_W(DIV_W)) i_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (div_en),
    .half  (cfg_half),
    .tick  (tick)
  );

  assign wait_en = (state == ST_WAIT_LO) || (state == ST_WAIT_HI);

  adc_busy_timer #(.TO_W(TO_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (wait_en),
    .limit   (cfg_timeout),
    .expired (expired)
  );

  assign req_ready = (state == ST_IDLE) && !res_valid;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cmd_sh    <= '0;
      res_sh    <= '0;
      chan_q    <= '0;
      bit_cnt   <= '0;
      gap_half  <= 1'b0;
      adc_cs_n  <= 1'b1;
      adc_sclk  <= 1'b0;
      adc_din   <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
      res_error <= 1'b0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cmd_sh   <= make_cmd(req_chan, req_span, req_bipolar);
            adc_din  <= make_cmd(req_chan, req_span, req_bipolar)[CMD_BITS-1];
            chan_q   <= req_chan;
            bit_cnt  <= '0;
            adc_cs_n <= 1'b0;
            state    <= ST_CMD;
          end
        end

        ST_CMD: begin
          if (tick) begin
            if (!adc_sclk) begin
              adc_sclk <= 1'b1;
            end else begin
              adc_sclk <= 1'b0;
              if (bit_cnt == LAST_CMD) begin
                adc_din <= 1'b0;
                state   <= ST_WAIT_LO;
              end else begin
                bit_cnt <= bit_cnt + CNT_W'(1);
                cmd_sh  <= {cmd_sh[CMD_BITS-2:0], 1'b0};
                adc_din <= cmd_sh[CMD_BITS-2];
              end
            end
          end
        end

        ST_WAIT_LO, ST_WAIT_HI: begin
          if (expired) begin
            adc_cs_n  <= 1'b1;
            res_valid <= 1'b1;
            res_error <= 1'b1;
            res_data  <= '0;
            res_chan  <= chan_q;
            gap_half  <= 1'b0;
            state     <= ST_GAP;
          end else if (state == ST_WAIT_LO) begin
            if (!sstrb_s) state <= ST_WAIT_HI;
          end else if (sstrb_s) begin
            res_sh  <= {{(RES_BITS-1){1'b0}}, adc_dout};
            bit_cnt <= '0;
            state   <= ST_READ;
          end
        end

        ST_READ: begin
          if (tick) begin
            if (!adc_sclk) begin
              adc_sclk <= 1'b1;
              if (bit_cnt != '0) res_sh <= {res_sh[RES_BITS-2:0], adc_dout};
            end else begin
              adc_sclk <= 1'b0;
              if (bit_cnt == LAST_RES) begin
                adc_cs_n  <= 1'b1;
                res_valid <= 1'b1;
                res_error <= 1'b0;
                res_data  <= res_sh;
                res_chan  <= chan_q;
                gap_half  <= 1'b0;
                state     <= ST_GAP;
              end else begin
                bit_cnt <= bit_cnt + CNT_W'(1);
              end
            end
          end
        end

        ST_GAP: begin
          if (tick) begin
            if (gap_half) state <= ST_IDLE;
            else          gap_half <= 1'b1;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        res_valid,
  input logic        res_ready,
  input logic [11:0] res_data,
  input logic [2:0]  res_chan,
  input logic        res_error,
  input logic        adc_cs_n,
  input logic        adc_sclk,
  input logic        adc_din,
  input logic        adc_sstrb
);
  a_r2_din_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sclk) |-> $stable(adc_din));

  a_r4_sclk_parked_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && !adc_sstrb) |-> !adc_sclk);

  a_r7_error_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_error) |-> (res_data == 12'd0));

  a_r8_cs_high_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> adc_cs_n);

  a_r8_sclk_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  a_r9_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)
                                   && $stable(res_chan) && $stable(res_error)));

  a_r9_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid);

  a_r9_select_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(req_valid && req_ready));
endmodule

bind adc_host_ctrl adc_host_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_chan  (res_chan),
  .res_error (res_error),
  .adc_cs_n  (adc_cs_n),
  .adc_sclk  (adc_sclk),
  .adc_din   (adc_din),
  .adc_sstrb (adc_sstrb)
);

// File: tb/test_adc_host_ctrl.sv
module test_adc_host_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_half = 8'd2;
  logic [15:0] cfg_timeout = 16'd4000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_chan = 3'd0;
  logic        req_span = 1'b0;
  logic        req_bipolar = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [11:0] res_data;
  logic [2:0]  res_chan;
  logic        res_error;
  logic        adc_cs_n;
  logic        adc_sclk;
  logic        adc_din;
  logic        adc_dout;
  logic        adc_sstrb;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  // converter settings written only by the tasks
  logic [11:0] tb_value = 12'h000;
  int          tb_conv  = 40;
  logic        tb_stall = 1'b0;

  always #2.5 clk = ~clk;

  adc_host_ctrl i_adc_host_ctrl (
    .clk (clk), .rst_n (rst_n), .cfg_half (cfg_half), .cfg_timeout (cfg_timeout),
    .req_valid (req_valid), .req_ready (req_ready), .req_chan (req_chan),
    .req_span (req_span), .req_bipolar (req_bipolar),
    .res_valid (res_valid), .res_ready (res_ready), .res_data (res_data),
    .res_chan (res_chan), .res_error (res_error),
    .adc_cs_n (adc_cs_n), .adc_sclk (adc_sclk), .adc_din (adc_din),
    .adc_dout (adc_dout), .adc_sstrb (adc_sstrb)
  );

  // behavioural converter serial interface
  typedef enum {M_CMD, M_BUSY, M_OUT} mph_e;
  mph_e        m_ph = M_CMD;
  logic        m_sclk_q = 1'b0;
  logic        m_cs_q = 1'b1;
  logic [7:0]  m_cmd = 8'h00;
  int          m_bits = 0, m_busy = 0, m_idx = 0, m_rises = 0;
  int          m_hi_len = 0, m_lo_len = 0, m_bad_hi = 0, m_min_lo = 1000000;
  int          m_viol = 0, m_hi_cnt = 0;
  int          last_rises = 0, last_bad_hi = 0, last_min_lo = 0, last_viol = 0, last_gap = 0;
  logic [7:0]  last_cmd = 8'h00;
  logic        m_seen_lo_edge = 1'b0;
  int          m_exp_half = 2;

  always @(posedge clk) begin
    m_sclk_q <= adc_sclk;
    m_cs_q   <= adc_cs_n;
    if (adc_cs_n) begin
      m_hi_cnt <= m_hi_cnt + 1;
      if (!m_cs_q) begin
        last_rises  <= m_rises;
        last_bad_hi <= m_bad_hi;
        last_min_lo <= m_min_lo;
        last_viol   <= m_viol;
        last_cmd    <= m_cmd;
      end
      m_ph <= M_CMD; m_bits <= 0; adc_sstrb <= 1'b1; adc_dout <= 1'b0;
    end else begin
      if (m_cs_q) begin
        last_gap <= m_hi_cnt; m_hi_cnt <= 0;
        m_rises <= 0; m_bad_hi <= 0; m_min_lo <= 1000000; m_viol <= 0;
        m_hi_len <= 0; m_lo_len <= 0; m_seen_lo_edge <= 1'b0;
      end else begin
        if (adc_sclk) m_hi_len <= m_hi_len + 1; else m_lo_len <= m_lo_len + 1;
        if (adc_sclk && !m_sclk_q) begin
          m_rises <= m_rises + 1;
          if (m_seen_lo_edge && m_lo_len < m_min_lo) m_min_lo <= m_lo_len;
          m_hi_len <= 1;
          if (m_ph == M_CMD) begin
            m_cmd <= {m_cmd[6:0], adc_din};
            m_bits <= m_bits + 1;
          end
        end
        if (!adc_sclk && m_sclk_q) begin
          if (m_hi_len != m_exp_half) m_bad_hi <= m_bad_hi + 1;
          m_lo_len <= 1;
          m_seen_lo_edge <= 1'b1;
          if (m_ph == M_CMD && m_bits == 8) begin
            adc_sstrb <= 1'b0; m_busy <= tb_conv; m_ph <= M_BUSY;
          end else if (m_ph == M_OUT) begin
            adc_dout <= (m_idx >= 0) ? tb_value[m_idx] : 1'b0;
            m_idx <= m_idx - 1;
          end
        end
        if (m_ph == M_BUSY) begin
          if (adc_sclk) m_viol <= m_viol + 1;
          if (!tb_stall) begin
            if (m_busy <= 1) begin
              adc_sstrb <= 1'b1; adc_dout <= tb_value[11]; m_idx <= 10; m_ph <= M_OUT;
            end else m_busy <= m_busy - 1;
          end
        end
      end
    end
  end

  initial begin
    adc_sstrb = 1'b1;
    adc_dout  = 1'b0;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog (R1..all requirements): actual hung run, expected completion");
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int eff_half(input int h);
    return (h < 2) ? 2 : h;
  endfunction

  // offer a request and wait until it is accepted
  task automatic issue(input logic [2:0] ch, input logic sp, input logic bp);
    @(negedge clk);
    req_chan = ch; req_span = sp; req_bipolar = bp; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_result();
    while (!res_valid) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 cs_n", adc_cs_n, 1);
    chk(adc_sclk == 1'b0, "R1 sclk", adc_sclk, 0);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
  endtask

  task automatic t_convert(input logic [2:0] ch, input logic sp, input logic bp,
                           input int half, input int conv, input logic [11:0] val);
    logic [7:0] exp_cmd;
    cfg_half = 8'(half); m_exp_half = eff_half(half);
    tb_value = val; tb_conv = conv; tb_stall = 1'b0; cfg_timeout = 16'd4000;
    exp_cmd = {1'b1, ch, sp, bp, 2'b00};
    issue(ch, sp, bp);
    wait_result();
    @(negedge clk);
    chk(res_error == 1'b0, "R7 no error", res_error, 0);
    chk(res_data == val, "R5 data", res_data, val);
    chk(res_chan == ch, "R6 chan", res_chan, ch);
    chk(last_cmd == exp_cmd, "R2 command byte", last_cmd, exp_cmd);
    chk(last_rises == 20, "R10 rising edges", last_rises, 20);
    chk(last_bad_hi == 0, "R3 high phase length", last_bad_hi, 0);
    chk(last_min_lo >= eff_half(half), "R3 low phase length", last_min_lo, eff_half(half));
    chk(last_viol == 0, "R4 sclk while busy", last_viol, 0);
    chk(adc_cs_n == 1'b1, "R8 cs high on result", adc_cs_n, 1);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid == 1'b0, "R9 response consumed", res_valid, 0);
  endtask

  task automatic t_timeout();
    cfg_half = 8'd2; m_exp_half = 2;
    tb_value = 12'hFFF; tb_stall = 1'b1; cfg_timeout = 16'd100;
    issue(3'd6, 1'b1, 1'b0);
    wait_result();
    @(negedge clk);
    chk(res_error == 1'b1, "R7 error flag", res_error, 1);
    chk(res_data == 12'd0, "R7 data zero", res_data, 0);
    chk(res_chan == 3'd6, "R6 chan on error", res_chan, 6);
    chk(adc_cs_n == 1'b1, "R7 cs released", adc_cs_n, 1);
    chk(last_rises == 8, "R7 only command clocks", last_rises, 8);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    tb_stall = 1'b0; cfg_timeout = 16'd4000;
  endtask

  task automatic t_backpressure();
    logic [11:0] held;
    cfg_half = 8'd3; m_exp_half = 3;
    tb_value = 12'h5A3; tb_conv = 30; tb_stall = 1'b0;
    issue(3'd2, 1'b0, 1'b1);
    wait_result();
    held = res_data;
    repeat (20) @(negedge clk);
    chk(res_valid == 1'b1, "R9 valid held", res_valid, 1);
    chk(res_data == held, "R9 data held", res_data, held);
    chk(req_ready == 1'b0, "R9 no accept while pending", req_ready, 0);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic t_back_to_back();
    cfg_half = 8'd5; m_exp_half = 5;
    tb_value = 12'h3C3; tb_conv = 25; tb_stall = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    req_chan = 3'd4; req_span = 1'b1; req_bipolar = 1'b1; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    while (adc_cs_n) @(negedge clk);
    while (!adc_cs_n) @(negedge clk);
    while (adc_cs_n) @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(last_gap >= 10, "R8 release gap", last_gap, 10);
    wait_result();
    @(negedge clk);
    chk(res_data == 12'h3C3, "R5 second data", res_data, 12'h3C3);
    res_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_convert(3'd0, 1'b0, 1'b0, 2, 40,  12'hA5C);
    t_convert(3'd7, 1'b1, 1'b1, 3, 120, 12'h001);
    t_convert(3'd5, 1'b0, 1'b1, 1, 60,  12'h800);
    t_convert(3'd3, 1'b1, 1'b0, 5, 300, 12'hFFF);
    t_convert(3'd1, 1'b0, 1'b0, 2, 10,  12'h000);
    t_convert(3'd6, 1'b1, 1'b1, 4, 80,  12'h555);
    t_timeout();
    t_convert(3'd2, 1'b1, 1'b0, 2, 50,  12'hAAA);
    t_backpressure();
    t_back_to_back();
    summary();
    $finish;
  end
endmodule